// File: doc/BRIEF.md
# Scaled Sine Burst Generator

The block plays out a counted burst of whole sine periods. A fixed table of one sine period is computed when the design is elaborated. A single index walks through that table, and the index wraps with a bit mask, so the table depth is a power of two and no divider is needed. Each table value is signed and is multiplied by an unsigned 16-bit amplitude. The product is then shifted right by 16 bits, so the sample stays within 16 bits. Reading the table and scaling the value are two separate register stages. This lets a new sample come out on every clock when the pace allows it.

One accepted `start` latches two settings: a tick interval N, which gives one sample every N clocks, and a period count P. The block then emits exactly P times 1024 samples and pulses `done`. The output is a one-way stream: `sample_valid` qualifies `sample` for one clock. The stream has no ready input and so no back-pressure. The consumer must take every sample in the clock it is flagged. Pacing comes only from the tick interval. `amplitude` is not latched and should be held steady during a burst. The value that applies to a sample is the one present one clock before that sample is flagged valid.

Top module: `sine_burst_gen`

## Requirements
- R1: The table has 1024 entries, and entry i equals round(32767·sin(2πi/1024)) in two's complement. Sample k of a burst, counted from 0, uses entry k mod 1024.
- R2: Each emitted sample equals floor(entry × amplitude / 65536), where amplitude is unsigned. An amplitude of 0 gives 0, and 0xFFFF gives entry 32767 as 32766.
- R3: Consecutive `sample_valid` pulses are exactly N clocks apart, where N is `tick_interval` latched at start. An interval of 0 acts as 1. With N of 2 or more, `sample_valid` is low between samples.
- R4: The first `sample_valid` of a burst is high in the clock after the (N+1)th rising edge that follows the edge accepting `start`.
- R5: A burst emits exactly 1024·P samples. After index 1023 the index wraps to 0 and the next period begins with no gap.
- R6: `done` is high for one clock, in the same clock as the last `sample_valid`, and `busy` is low in that clock. `busy` is high from the clock after acceptance until then. `sample_valid` is never high unless `busy` or `done` is high.
- R7: A `period_count` of 0 gives `done` in the clock after acceptance, with no sample, and `busy` stays low.
- R8: `start` while `busy` is high is ignored. The sample count, the pace and the index of the running burst are unchanged.
- R9: `start` during the clock in which `done` is high is accepted, and a new burst begins.
- R10: Synchronous reset clears `busy`, `done` and `sample_valid`. Nothing is emitted until a start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Burst request, accepted when busy is low |
| amplitude | input | 16 | Unsigned gain factor, applied live |
| tick_interval | input | 16 | Clocks per sample, latched at start (0 acts as 1) |
| period_count | input | 16 | Whole sine periods per burst, latched at start |
| sample | output | 16 | Scaled signed sample |
| sample_valid | output | 1 | One-clock qualifier for sample |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-clock end-of-burst pulse |

## Verification
The end of one burst and the acceptance of the next can fall in the same clock. Because `busy` is already low while `done` is high, a `start` held during the `done` clock must be taken. The bench drives `start` in exactly that clock. It then judges that the last sample of the old burst and `done` share a clock with `busy` low, and that the new burst's first sample arrives N+1 edges after acceptance, beginning again at table entry 0. A second collision, `start` in the middle of a burst, is judged by an unchanged sample count and pace.

// File: rtl/sine_burst_pkg.sv
package sine_burst_pkg;

  // Signed full-scale sine code for table entry idx of a depth-point period.
  function automatic int sine_code(input int idx, input int depth, input int width);
    real pi, x, x2, term, acc, full;
    int  n;
    pi = 3.14159265358979323846;
    x  = 2.0 * pi * $itor(idx) / $itor(depth);
    if (x > pi) x = x - 2.0 * pi;
    if (x > pi / 2.0) x = pi - x;
    if (x < -pi / 2.0) x = -pi - x;
    x2   = x * x;
    term = x;
    acc  = x;
    for (n = 1; n < 12; n++) begin
      term = -term * x2 / $itor((2 * n) * (2 * n + 1));
      acc  = acc + term;
    end
    full = $itor((1 << (width - 1)) - 1);
    acc  = acc * full;
    if (acc >= 0.0) return $rtoi(acc + 0.5);
    else            return -$rtoi(-acc + 0.5);
  endfunction

endpackage

// File: rtl/sb_pacer.sv
module sb_pacer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] interval,
  input  logic          run,
  output logic          step
);
  logic [TW-1:0] lim_q;
  logic [TW-1:0] cnt_q;

  assign step = run && (cnt_q == lim_q - TW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      lim_q <= TW'(1);
      cnt_q <= '0;
    end else if (load) begin
      lim_q <= (interval == '0) ? TW'(1) : interval;
      cnt_q <= '0;
    end else if (run) begin
      if (step) cnt_q <= '0;
      else      cnt_q <= cnt_q + TW'(1);
    end
  end
endmodule

// File: rtl/sb_sequencer.sv
module sb_sequencer #(
  parameter int IDXW = 10,
  parameter int PW   = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            accept,
  input  logic [PW-1:0]   periods,
  input  logic            step,
  output logic            running,
  output logic [IDXW-1:0] idx,
  output logic            last_issue,
  output logic            zero_done
);
  localparam logic [IDXW-1:0] MASK = {IDXW{1'b1}};

  logic            running_q;
  logic [IDXW-1:0] idx_q;
  logic [PW-1:0]   left_q;
  logic            zero_q;

  assign running    = running_q;
  assign idx        = idx_q;
  assign zero_done  = zero_q;
  assign last_issue = step && (idx_q == MASK) && (left_q == PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running_q <= 1'b0;
      idx_q     <= '0;
      left_q    <= '0;
      zero_q    <= 1'b0;
    end else if (accept) begin
      idx_q     <= '0;
      left_q    <= periods;
      running_q <= (periods != '0);
      zero_q    <= (periods == '0);
    end else begin
      zero_q <= 1'b0;
      if (step) begin
        idx_q <= (idx_q + IDXW'(1)) & MASK;
        if (idx_q == MASK) begin
          left_q <= left_q - PW'(1);
          if (left_q == PW'(1)) running_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sb_sine_rom.sv
module sb_sine_rom #(
  parameter int IDXW = 10,
  parameter int SW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [IDXW-1:0]      addr,
  input  logic                 last_in,
  output logic                 out_v,
  output logic signed [SW-1:0] out_data,
  output logic                 out_last
);
  localparam int DEPTH = 1 << IDXW;

  logic signed [SW-1:0] table_w [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam int CODE = sine_burst_pkg::sine_code(g, DEPTH, SW);
    assign table_w[g] = SW'(CODE);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      out_last <= 1'b0;
      out_data <= '0;
    end else begin
      out_v    <= rd_en;
      out_last <= rd_en && last_in;
      if (rd_en) out_data <= table_w[addr];
    end
  end
endmodule

// File: rtl/sb_scaler.sv
module sb_scaler #(
  parameter int SW = 16,
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_v,
  input  logic signed [SW-1:0] in_data,
  input  logic                 in_last,
  input  logic [AW-1:0]        amp,
  output logic                 out_v,
  output logic signed [SW-1:0] out_data,
  output logic                 out_last
);
  localparam int PRW = SW + AW + 1;

  logic signed [PRW-1:0] prod;

  assign prod = $signed(in_data) * $signed({1'b0, amp});

  always_ff @(posedge clk) begin
    if (rst) begin
      out_v    <= 1'b0;
      out_last <= 1'b0;
      out_data <= '0;
    end else begin
      out_v    <= in_v;
      out_last <= in_v && in_last;
      if (in_v) out_data <= SW'(prod >>> AW);
    end
  end
endmodule

// File: rtl/sine_burst_gen.sv
module sine_burst_gen #(
  parameter int IDXW = 10,
  parameter int SW   = 16,
  parameter int AW   = 16,
  parameter int TW   = 16,
  parameter int PW   = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [AW-1:0]        amplitude,
  input  logic [TW-1:0]        tick_interval,
  input  logic [PW-1:0]        period_count,
  output logic signed [SW-1:0] sample,
  output logic                 sample_valid,
  output logic                 busy,
  output logic                 done
);
  logic                 accept;
  logic                 step;
  logic                 running;
  logic [IDXW-1:0]      idx;
  logic                 last_issue;
  logic                 zero_done;
  logic                 rom_v;
  logic                 rom_last;
  logic signed [SW-1:0] rom_data;
  logic                 out_last;

  assign busy   = running || rom_v;
  assign accept = start && !busy;
  assign done   = (sample_valid && out_last) || zero_done;

  sb_pacer #(.TW(TW)) u_pacer (
    .clk(clk), .rst(rst), .load(accept), .interval(tick_interval),
    .run(running), .step(step)
  );

  sb_sequencer #(.IDXW(IDXW), .PW(PW)) u_seq (
    .clk(clk), .rst(rst), .accept(accept), .periods(period_count),
    .step(step), .running(running), .idx(idx),
    .last_issue(last_issue), .zero_done(zero_done)
  );

  sb_sine_rom #(.IDXW(IDXW), .SW(SW)) u_rom (
    .clk(clk), .rst(rst), .rd_en(step), .addr(idx), .last_in(last_issue),
    .out_v(rom_v), .out_data(rom_data), .out_last(rom_last)
  );

  sb_scaler #(.SW(SW), .AW(AW)) u_scale (
    .clk(clk), .rst(rst), .in_v(rom_v), .in_data(rom_data),
    .in_last(rom_last), .amp(amplitude), .out_v(sample_valid),
    .out_data(sample), .out_last(out_last)
  );
endmodule

// File: rtl/sine_burst_chk.sv
module sine_burst_chk #(
  parameter int IDXW = 10,
  parameter int PW   = 16
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic [PW-1:0]   period_count,
  input logic            sample_valid,
  input logic            busy,
  input logic            done,
  input logic            step,
  input logic [IDXW-1:0] idx
);
  localparam logic [IDXW-1:0] MASK = {IDXW{1'b1}};

  assert_index_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (step && idx == MASK) |=> (idx == '0));

  assert_done_not_busy_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_valid_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (busy || done));

  assert_zero_periods_R7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && period_count == '0) |=> (done && !busy));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && !step) |=> (idx == $past(idx)));
endmodule

bind sine_burst_gen sine_burst_chk #(.IDXW(IDXW), .PW(PW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .period_count(period_count),
  .sample_valid(sample_valid), .busy(busy), .done(done),
  .step(step), .idx(idx)
);

// File: tb/sine_burst_gen_test.sv
`timescale 1ns/1ps
module sine_burst_gen_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] amplitude = '0;
  logic [15:0] tick_interval = '0;
  logic [15:0] period_count = '0;
  logic signed [15:0] sample;
  logic        sample_valid, busy, done;

  always #4 clk = ~clk;

  sine_burst_gen uut (
    .clk(clk), .rst(rst), .start(start), .amplitude(amplitude),
    .tick_interval(tick_interval), .period_count(period_count),
    .sample(sample), .sample_valid(sample_valid), .busy(busy), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int tbl [1024];
  longint cyc = 0;

  // monitor state
  int     exp_amp = 0;
  int     exp_gap = 1;
  int     mon_cnt = 0, val_bad = 0, gap_bad = 0, done_cnt = 0;
  longint first_cyc = 0, last_cyc = 0, done_cyc = 0;
  logic   done_busy = 1'b0, done_valid = 1'b0;
  int     bad_val_act = 0, bad_val_exp = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exp_sample(int k, int a);
    longint p;
    p = longint'(tbl[k % 1024]) * longint'(a);
    return int'(p >>> 16);
  endfunction

  always @(negedge clk) begin
    if (sample_valid) begin
      int e, d;
      e = exp_sample(mon_cnt, exp_amp);
      d = int'(sample) - e;
      if (d > 1 || d < -1) begin
        if (val_bad == 0) begin bad_val_act = int'(sample); bad_val_exp = e; end
        val_bad++;
      end
      if (mon_cnt == 0) first_cyc = cyc;
      else if (cyc - last_cyc != longint'(exp_gap)) gap_bad++;
      last_cyc = cyc;
      mon_cnt++;
    end
    if (done) begin
      done_cnt++;
      done_cyc   = cyc;
      done_busy  = busy;
      done_valid = sample_valid;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clear_mon();
    mon_cnt = 0; val_bad = 0; gap_bad = 0; done_cnt = 0;
  endtask

  // drive start for one clock; returns cycle count of accepting edge
  task automatic kick(input int a, input int n, input int p, output longint acc);
    @(negedge clk);
    amplitude = 16'(a); tick_interval = 16'(n); period_count = 16'(p);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc = cyc;
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit && done_cnt == 0; i++) @(negedge clk);
  endtask

  task automatic burst(input string tag, input int a, input int n, input int p);
    longint acc;
    int neff;
    neff = (n == 0) ? 1 : n;
    clear_mon();
    exp_amp = a; exp_gap = neff;
    kick(a, n, p, acc);
    wait_done(neff * 1024 * p + 50);
    check(val_bad == 0, {tag, " R1 R2 sample values"}, bad_val_act, bad_val_exp);
    check(gap_bad == 0, {tag, " R3 sample spacing"}, gap_bad, 0);
    check(first_cyc - acc == longint'(neff + 1), {tag, " R4 first-sample latency"},
          first_cyc - acc, neff + 1);
    check(mon_cnt == 1024 * p, {tag, " R5 sample count"}, mon_cnt, 1024 * p);
    check(done_cnt == 1 && done_cyc == last_cyc && !done_busy && done_valid,
          {tag, " R6 done with last sample"}, done_cyc, last_cyc);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !sample_valid, "R10 outputs low in reset",
          {busy, done, sample_valid}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check(mon_cnt == 0 && !busy, "R10 idle after reset", mon_cnt, 0);
  endtask

  task automatic t_zero_periods();
    longint acc;
    clear_mon();
    kick(16'h4000, 3, 0, acc);
    check(done && !busy, "R7 done one clock after accept", done, 1);
    repeat (10) @(negedge clk);
    check(mon_cnt == 0 && done_cnt == 1 && !busy, "R7 no samples", mon_cnt, 0);
  endtask

  task automatic t_ignore_busy();
    longint acc;
    clear_mon();
    exp_amp = 16'h3000; exp_gap = 2;
    kick(16'h3000, 2, 1, acc);
    repeat (300) @(negedge clk);
    check(busy, "R6 busy mid-burst", busy, 1);
    tick_interval = 16'd5; period_count = 16'd3; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(5000);
    check(mon_cnt == 1024, "R8 count unchanged by start while busy", mon_cnt, 1024);
    check(gap_bad == 0 && val_bad == 0, "R8 pace and values unchanged", gap_bad, 0);
    repeat (20) @(negedge clk);
    check(mon_cnt == 1024 && !busy, "R8 no second burst", mon_cnt, 1024);
  endtask

  task automatic t_back_to_back();
    longint acc;
    clear_mon();
    exp_amp = 16'h7FFF; exp_gap = 1;
    kick(16'h7FFF, 1, 1, acc);
    for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
    check(done && !busy && sample_valid, "R6 done cycle shares last sample", done, 1);
    tick_interval = 16'd3; period_count = 16'd1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    acc = cyc;
    clear_mon();
    exp_gap = 3;
    wait_done(5000);
    check(first_cyc - acc == 4, "R9 start in done clock accepted", first_cyc - acc, 4);
    check(mon_cnt == 1024 && val_bad == 0, "R9 new burst restarts at entry 0", mon_cnt, 1024);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < 1024; i++) begin
      real x;
      x = 32767.0 * $sin(2.0 * 3.14159265358979323846 * $itor(i) / 1024.0);
      tbl[i] = (x >= 0.0) ? $rtoi(x + 0.5) : -$rtoi(-x + 0.5);
    end
    t_reset();
    burst("full amp N=1", 16'hFFFF, 1, 1);
    burst("half amp N=3 two periods", 16'h8000, 3, 2);
    burst("zero amp", 0, 2, 1);
    burst("interval zero", 16'h1234, 0, 1);
    t_zero_periods();
    t_ignore_busy();
    t_back_to_back();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule